// File: doc/BRIEF.md
# Bit-Serial Associative Processor Array

This block is a one-dimensional row of small processing elements. Each element holds a 42-bit memory word and three one-bit registers, R1, R2 and R3. An external controller issues one instruction at a time, and every element executes it in lockstep. The instruction set covers six operations. A masked comparison of every word against a broadcast pattern loads a per-word hit flag into a register. A truth-table function of the three registers writes one of them. The lowest selected word can be read onto a shared bus. A bus value can be written into all selected words. R1 can be moved to a neighbouring element. Any register can be stored into one memory column. An element counts as selected when its R1 is 1. A comparison whose mask enables a single column is the normal way to lift that column into a register. Multi-bit work is built from chains of these single-bit steps, run across all words at once.

Each operation has a fixed cycle cost, and a small controller sequences it. The controller has two states. In `ST_IDLE` it waits for a request. The transition `ST_IDLE -> ST_RUN` happens on a clock edge that sees `instr_valid` high, and on that edge the instruction fields are latched and a down-counter is loaded. In `ST_RUN` the counter falls by one per cycle. When the counter is zero, the transition `ST_RUN -> ST_IDLE` commits the operation's effect into every element in one edge and raises `done` for one cycle.

Top module: `assoc_array_top`

## Requirements
- R1: After reset, every memory word and every R1, R2 and R3 is 0, `busy` and `done` are low, and `bus_out` is 0.
- R2: Opcode 0 (compare) sets, in every word, the register picked by `instr_reg` (0=R1, 1=R2, 2=R3, 3=no register) to 1 exactly when the word equals `instr_pattern` on every bit whose `instr_care` bit is 1. Bits whose care bit is 0 are ignored. Memory is unchanged. The cost is 4 cycles.
- R3: A compare with a single care bit set at column c and a pattern of 1 there loads bit c of each word into the target register.
- R4: Opcode 1 (function) writes `instr_tt[{R3,R2,R1}]` of each element into the register picked by `instr_reg`. With reg code 3 nothing changes. The cost is 2 cycles.
- R5: Opcode 2 (read) loads `bus_out` with the lowest-indexed word whose R1 is 1, or with 0 if no R1 is set. `bus_out` holds its value until the next read. The cost is 3 cycles.
- R6: Opcode 3 (write) copies `instr_pattern` into every word whose R1 is 1 and leaves the other words unchanged. The cost is 2 cycles.
- R7: Opcode 4 (shift) sets R1 of element i to the old R1 of element i-1 when `instr_dir` is 0, or of element i+1 when it is 1. The edge element that has no source receives 0. R2, R3 and memory are unchanged. The cost is 2 cycles.
- R8: Opcode 5 (column store) writes the register picked by `instr_reg` into bit `instr_col` of every word. A column index of 42 or more, or reg code 3, changes nothing. The cost is 2 cycles.
- R9: `busy` goes high in the cycle after the edge that accepts a request and stays high for exactly the cost of that opcode. All effects are visible once `busy` is low.
- R10: `instr_valid` is ignored while `busy` is high.
- R11: `done` is high for exactly one cycle: the first cycle in which `busy` is low after an instruction.
- R12: Opcodes 6 and 7 cost 2 cycles and change no word, register or bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Request strobe, taken when idle |
| instr_op | input | 3 | Opcode |
| instr_reg | input | 2 | Register select: target, or source for column store |
| instr_pattern | input | 42 | Compare pattern, or write data |
| instr_care | input | 42 | Per-bit compare enable (1 = compare) |
| instr_tt | input | 8 | Truth table for the function opcode |
| instr_col | input | 6 | Column index for column store |
| instr_dir | input | 1 | Shift direction: 0 toward higher index, 1 toward lower |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_out | output | 42 | Shared read bus |

## Verification
Two events can coincide. A new request can arrive in a cycle where the previous instruction is still counting down, and that cycle can also be the one in which the previous instruction's effect commits. To provoke this, the bench keeps `instr_valid` high for the whole busy window and drives a destructive write opcode with an all-ones pattern. It then reads every word back through its row address and compares each with an arithmetic model. Any leaked acceptance, or a cost that is too short, shows up as a corrupted word or a wrong busy count. Selection conflicts are covered in the same way. Compares that select several words are read back to confirm that the lowest index wins.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

    typedef enum logic [2:0] {
        OP_MATCH = 3'd0,
        OP_CALC  = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_SHIFT = 3'd4,
        OP_WRCOL = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        RS_R1   = 2'd0,
        RS_R2   = 2'd1,
        RS_R3   = 2'd2,
        RS_NONE = 2'd3
    } rsel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    localparam int CNT_W = 3;

    function automatic logic [CNT_W-1:0] op_cycles(op_e op);
        case (op)
            OP_MATCH: return 3'd4;
            OP_READ:  return 3'd3;
            default:  return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/assoc_ctrl.sv
module assoc_ctrl
    import assoc_pkg::*;
#(
    parameter int WORD_W = 42,
    parameter int COL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  op_e               req_op,
    input  rsel_e             req_reg,
    input  logic [WORD_W-1:0] req_pattern,
    input  logic [WORD_W-1:0] req_care,
    input  logic [7:0]        req_tt,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_dir,
    output logic              busy,
    output logic              done,
    output logic              commit,
    output op_e               op_q,
    output rsel_e             reg_q,
    output logic [WORD_W-1:0] pattern_q,
    output logic [WORD_W-1:0] care_q,
    output logic [7:0]        tt_q,
    output logic [COL_W-1:0]  col_q,
    output logic              dir_q
);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             accept;
    logic             done_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = ST_RUN;
                    cnt_d   = op_cycles(req_op) - 3'd1;
                end
            end
            ST_RUN: begin
                if (cnt_q == '0) begin
                    commit  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 3'd1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= commit;
        end
    end

    // instruction latch, loaded on acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_RSV6;
            reg_q     <= RS_NONE;
            pattern_q <= '0;
            care_q    <= '0;
            tt_q      <= '0;
            col_q     <= '0;
            dir_q     <= 1'b0;
        end else if (accept) begin
            op_q      <= req_op;
            reg_q     <= req_reg;
            pattern_q <= req_pattern;
            care_q    <= req_care;
            tt_q      <= req_tt;
            col_q     <= req_col;
            dir_q     <= req_dir;
        end
    end

    // outputs
    always_comb begin
        busy = (state_q == ST_RUN);
        done = done_q;
    end

endmodule

// File: rtl/assoc_pe.sv
module assoc_pe
    import assoc_pkg::*;
#(
    parameter int WORD_W = 42,
    parameter int COL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_e               op,
    input  rsel_e             rsel,
    input  logic [WORD_W-1:0] pattern,
    input  logic [WORD_W-1:0] care,
    input  logic [7:0]        tt,
    input  logic [COL_W-1:0]  col,
    input  logic              dir,
    input  logic              nb_lo,
    input  logic              nb_hi,
    output logic [WORD_W-1:0] word_o,
    output logic              r1_o
);

    logic [WORD_W-1:0] word_q, word_d;
    logic              r1_q, r2_q, r3_q;
    logic              r1_d, r2_d, r3_d;
    logic              hit, fn_bit, src_bit, col_ok, reg_val;

    always_comb begin
        hit    = &(~(word_q ^ pattern) | ~care);
        fn_bit = tt[{r3_q, r2_q, r1_q}];
        unique case (rsel)
            RS_R1:   src_bit = r1_q;
            RS_R2:   src_bit = r2_q;
            RS_R3:   src_bit = r3_q;
            default: src_bit = 1'b0;
        endcase
        col_ok  = (rsel != RS_NONE) && (int'(col) < WORD_W);
        reg_val = (op == OP_MATCH) ? hit : fn_bit;
    end

    always_comb begin
        word_d = word_q;
        r1_d   = r1_q;
        r2_d   = r2_q;
        r3_d   = r3_q;
        if (commit) begin
            unique case (op)
                OP_MATCH, OP_CALC: begin
                    unique case (rsel)
                        RS_R1:   r1_d = reg_val;
                        RS_R2:   r2_d = reg_val;
                        RS_R3:   r3_d = reg_val;
                        default: ;
                    endcase
                end
                OP_WRITE: begin
                    if (r1_q) word_d = pattern;
                end
                OP_SHIFT: begin
                    r1_d = dir ? nb_hi : nb_lo;
                end
                OP_WRCOL: begin
                    if (col_ok) word_d[col] = src_bit;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            r1_q   <= 1'b0;
            r2_q   <= 1'b0;
            r3_q   <= 1'b0;
        end else begin
            word_q <= word_d;
            r1_q   <= r1_d;
            r2_q   <= r2_d;
            r3_q   <= r3_d;
        end
    end

    assign word_o = word_q;
    assign r1_o   = r1_q;

endmodule

// File: rtl/assoc_pick.sv
module assoc_pick #(
    parameter int N_WORDS = 16,
    parameter int WORD_W  = 42
) (
    input  logic [WORD_W-1:0]  words [N_WORDS],
    input  logic [N_WORDS-1:0] sel,
    output logic [WORD_W-1:0]  word_o
);

    // descending scan so the lowest selected index wins
    always_comb begin
        word_o = '0;
        for (int i = N_WORDS - 1; i >= 0; i--) begin
            if (sel[i]) word_o = words[i];
        end
    end

endmodule

// File: rtl/assoc_array_top.sv
module assoc_array_top
    import assoc_pkg::*;
#(
    parameter int N_WORDS = 16,
    parameter int WORD_W  = 42,
    localparam int COL_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [2:0]        instr_op,
    input  logic [1:0]        instr_reg,
    input  logic [WORD_W-1:0] instr_pattern,
    input  logic [WORD_W-1:0] instr_care,
    input  logic [7:0]        instr_tt,
    input  logic [COL_W-1:0]  instr_col,
    input  logic              instr_dir,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] bus_out
);

    logic              commit;
    op_e               op_q;
    rsel_e             reg_q;
    logic [WORD_W-1:0] pattern_q, care_q;
    logic [7:0]        tt_q;
    logic [COL_W-1:0]  col_q;
    logic              dir_q;

    logic [WORD_W-1:0]         words [N_WORDS];
    logic [N_WORDS-1:0]        r1_vec;
    logic [N_WORDS*WORD_W-1:0] mem_flat;
    logic [WORD_W-1:0]         pick_word;
    logic [WORD_W-1:0]         bus_q;

    assoc_ctrl #(.WORD_W(WORD_W), .COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (instr_valid),
        .req_op      (op_e'(instr_op)),
        .req_reg     (rsel_e'(instr_reg)),
        .req_pattern (instr_pattern),
        .req_care    (instr_care),
        .req_tt      (instr_tt),
        .req_col     (instr_col),
        .req_dir     (instr_dir),
        .busy        (busy),
        .done        (done),
        .commit      (commit),
        .op_q        (op_q),
        .reg_q       (reg_q),
        .pattern_q   (pattern_q),
        .care_q      (care_q),
        .tt_q        (tt_q),
        .col_q       (col_q),
        .dir_q       (dir_q)
    );

    for (genvar g = 0; g < N_WORDS; g++) begin : g_pe
        logic lo, hi;
        if (g == 0) begin : g_lo_edge
            assign lo = 1'b0;
        end else begin : g_lo_link
            assign lo = r1_vec[g-1];
        end
        if (g == N_WORDS - 1) begin : g_hi_edge
            assign hi = 1'b0;
        end else begin : g_hi_link
            assign hi = r1_vec[g+1];
        end

        assoc_pe #(.WORD_W(WORD_W), .COL_W(COL_W)) u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .commit  (commit),
            .op      (op_q),
            .rsel    (reg_q),
            .pattern (pattern_q),
            .care    (care_q),
            .tt      (tt_q),
            .col     (col_q),
            .dir     (dir_q),
            .nb_lo   (lo),
            .nb_hi   (hi),
            .word_o  (words[g]),
            .r1_o    (r1_vec[g])
        );

        assign mem_flat[g*WORD_W +: WORD_W] = words[g];
    end

    assoc_pick #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_pick (
        .words  (words),
        .sel    (r1_vec),
        .word_o (pick_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else if (commit && op_q == OP_READ) begin
            bus_q <= pick_word;
        end
    end

    assign bus_out = bus_q;

endmodule

// File: rtl/assoc_array_chk.sv
module assoc_array_chk #(
    parameter int N_WORDS = 16,
    parameter int WORD_W  = 42
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      instr_valid,
    input logic [2:0]                instr_op,
    input logic                      busy,
    input logic                      done,
    input logic [WORD_W-1:0]         bus_out,
    input logic [N_WORDS*WORD_W-1:0] mem_flat,
    input logic [N_WORDS-1:0]        r1_vec
);

    logic [2:0] op_cap;
    logic [3:0] run_len;
    logic [3:0] want_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_cap  <= 3'd6;
            run_len <= '0;
        end else begin
            if (instr_valid && !busy) op_cap <= instr_op;
            run_len <= busy ? run_len + 4'd1 : 4'd0;
        end
    end

    always_comb begin
        case (op_cap)
            3'd0:    want_len = 4'd4;
            3'd2:    want_len = 4'd3;
            default: want_len = 4'd2;
        endcase
    end

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == want_len)); // R9

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11

    AST_BUS_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_out) |-> ($fell(busy) && op_cap == 3'd2)); // R5

    AST_MATCH_KEEPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_cap == 3'd0) |-> $stable(mem_flat)); // R2

    AST_QUIET_OUTSIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> ($stable(mem_flat) && $stable(r1_vec))); // R10

    AST_RSV_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_cap[2:1] == 2'b11) |-> ($stable(mem_flat) && $stable(r1_vec))); // R12

endmodule

bind assoc_array_top assoc_array_chk #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .busy        (busy),
    .done        (done),
    .bus_out     (bus_out),
    .mem_flat    (mem_flat),
    .r1_vec      (r1_vec)
);

// File: tb/assoc_array_top_tb_top.sv
module assoc_array_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int W = 42;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [2:0]    instr_op = '0;
    logic [1:0]    instr_reg = '0;
    logic [W-1:0]  instr_pattern = '0;
    logic [W-1:0]  instr_care = '0;
    logic [7:0]    instr_tt = '0;
    logic [CW-1:0] instr_col = '0;
    logic          instr_dir = 1'b0;
    logic          busy, done;
    logic [W-1:0]  bus_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [W-1:0] m_mem [N];
    bit           m_r1 [N];
    bit           m_r2 [N];
    bit           m_r3 [N];
    logic [W-1:0] m_bus;
    logic [W-1:0] amask;

    always #(CLK_PERIOD/2) clk = ~clk;

    assoc_array_top #(.N_WORDS(N), .WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_reg(instr_reg), .instr_pattern(instr_pattern), .instr_care(instr_care),
        .instr_tt(instr_tt), .instr_col(instr_col), .instr_dir(instr_dir),
        .busy(busy), .done(done), .bus_out(bus_out)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] addr_of(input int i);
        logic [W-1:0] a = '0;
        for (int b = 1; b <= i; b++) a[b] = 1'b1;
        return a;
    endfunction

    task automatic set_reg(input int i, input logic [1:0] rg, input bit v);
        case (rg)
            2'd0: m_r1[i] = v;
            2'd1: m_r2[i] = v;
            2'd2: m_r3[i] = v;
            default: ;
        endcase
    endtask

    task automatic model(input logic [2:0] op, input logic [1:0] rg, input logic [W-1:0] pat,
                         input logic [W-1:0] care, input logic [7:0] tt, input logic [CW-1:0] col,
                         input logic dir);
        bit old_r1 [N];
        for (int i = 0; i < N; i++) old_r1[i] = m_r1[i];
        case (op)
            3'd0: for (int i = 0; i < N; i++) set_reg(i, rg, ((m_mem[i] ^ pat) & care) == '0);
            3'd1: for (int i = 0; i < N; i++) set_reg(i, rg, tt[{m_r3[i], m_r2[i], m_r1[i]}]);
            3'd2: begin
                m_bus = '0;
                for (int i = N - 1; i >= 0; i--) if (m_r1[i]) m_bus = m_mem[i];
            end
            3'd3: for (int i = 0; i < N; i++) if (m_r1[i]) m_mem[i] = pat;
            3'd4: for (int i = 0; i < N; i++) begin
                if (dir) m_r1[i] = (i == N - 1) ? 1'b0 : old_r1[i+1];
                else     m_r1[i] = (i == 0) ? 1'b0 : old_r1[i-1];
            end
            3'd5: if (rg != 2'd3 && int'(col) < W) for (int i = 0; i < N; i++) begin
                case (rg)
                    2'd0: m_mem[i][col] = m_r1[i];
                    2'd1: m_mem[i][col] = m_r2[i];
                    default: m_mem[i][col] = m_r3[i];
                endcase
            end
            default: ;
        endcase
    endtask

    // issue one instruction at a negedge, wait for completion, check timing and model
    task automatic run_op(input logic [2:0] op, input logic [1:0] rg, input logic [W-1:0] pat,
                          input logic [W-1:0] care, input logic [7:0] tt, input logic [CW-1:0] col,
                          input logic dir, input bit junk, input string tag);
        int cost, cyc;
        cost = (op == 3'd0) ? 4 : (op == 3'd2) ? 3 : 2;
        instr_valid = 1'b1; instr_op = op; instr_reg = rg; instr_pattern = pat;
        instr_care = care; instr_tt = tt; instr_col = col; instr_dir = dir;
        @(posedge clk);
        @(negedge clk);
        cyc = 0;
        while (busy && cyc < 32) begin
            cyc++;
            if (junk) begin
                // R10: destructive request held while busy
                instr_valid = 1'b1; instr_op = 3'd3; instr_pattern = '1; instr_care = '1;
            end else begin
                instr_valid = 1'b0;
            end
            @(negedge clk);
        end
        instr_valid = 1'b0;
        chk(cyc == cost, "R9", 64'(cyc), 64'(cost));
        chk(done == 1'b1, "R11", 64'(done), 64'd1);
        model(op, rg, pat, care, tt, col, dir);
        if (op == 3'd2 || op[2:1] == 2'b11) chk(bus_out == m_bus, tag, 64'(bus_out), 64'(m_bus));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R11", {62'd0, done, busy}, 64'd0);
    endtask

    task automatic dump(input string tag, input int upto);
        for (int i = 0; i < upto; i++) begin
            run_op(3'd0, 2'd0, addr_of(i), amask, 8'h00, '0, 1'b0, 1'b0, tag);
            run_op(3'd2, 2'd0, '0, '0, 8'h00, '0, 1'b0, 1'b0, tag);
        end
    endtask

    initial begin
        amask = '0;
        for (int b = 1; b < N; b++) amask[b] = 1'b1;
        for (int i = 0; i < N; i++) begin
            m_mem[i] = '0; m_r1[i] = 0; m_r2[i] = 0; m_r3[i] = 0;
        end
        m_bus = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        chk(busy == 1'b0 && done == 1'b0, "R1", {62'd0, busy, done}, 64'd0);
        chk(bus_out == '0, "R1", 64'(bus_out), 64'd0);
        // R5: read with nothing selected
        run_op(3'd2, 2'd0, '0, '0, 8'h00, '0, 1'b0, 1'b0, "R5");
        // R1: all words compare equal to zero after reset
        run_op(3'd0, 2'd0, '0, '1, 8'h00, '0, 1'b0, 1'b0, "R1");
        run_op(3'd2, 2'd0, '0, '0, 8'h00, '0, 1'b0, 1'b0, "R1");

        // R2, R7, R8: all-wildcard compare then thermometer row addresses
        run_op(3'd0, 2'd0, '1, '0, 8'h00, '0, 1'b0, 1'b0, "R2");
        for (int k = 1; k < N; k++) begin
            run_op(3'd4, 2'd0, '0, '0, 8'h00, '0, 1'b0, 1'b0, "R7");
            run_op(3'd5, 2'd0, '0, '0, 8'h00, CW'(k), 1'b0, 1'b0, "R8");
        end
        dump("R7", N);

        // R6: load a distinct value into each word through single selection
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] v;
            logic [22:0]  mix;
            mix = 23'(i * 23'h1357) ^ 23'h2AAAA;
            v = addr_of(i);
            v[18:16] = 3'(i);
            v[41:19] = mix;
            run_op(3'd0, 2'd0, addr_of(i), amask, 8'h00, '0, 1'b0, 1'b0, "R2");
            run_op(3'd3, 2'd0, v, '0, 8'h00, '0, 1'b0, 1'b0, "R6");
        end
        dump("R6", N);

        // R5: several selected, lowest index wins (odd words via column 16)
        run_op(3'd0, 2'd0, 42'(1) << 16, 42'(1) << 16, 8'h00, '0, 1'b0, 1'b0, "R3");
        run_op(3'd2, 2'd0, '0, '0, 8'h00, '0, 1'b0, 1'b0, "R5");

        // R3, R4: truth-table sweep over all 256 functions
        for (int t = 0; t < 256; t++) begin
            logic [1:0] d;
            d = 2'(t % 3);
            run_op(3'd0, 2'd0, 42'(1) << 16, 42'(1) << 16, 8'h00, '0, 1'b0, 1'b0, "R3");
            run_op(3'd0, 2'd1, 42'(1) << 17, 42'(1) << 17, 8'h00, '0, 1'b0, 1'b0, "R3");
            run_op(3'd0, 2'd2, 42'(1) << 18, 42'(1) << 18, 8'h00, '0, 1'b0, 1'b0, "R3");
            run_op(3'd1, d, '0, '0, 8'(t), '0, 1'b0, 1'b0, "R4");
            run_op(3'd5, d, '0, '0, 8'h00, CW'(20), 1'b0, 1'b0, "R8");
            if (t % 16 == 5 || t == 255) dump("R4", N);
        end

        // R7: shift toward lower index, top edge receives zero
        run_op(3'd0, 2'd0, 42'(1) << 16, 42'(1) << 16, 8'h00, '0, 1'b0, 1'b0, "R3");
        run_op(3'd4, 2'd0, '0, '0, 8'h00, '0, 1'b1, 1'b0, "R7");
        run_op(3'd5, 2'd0, '0, '0, 8'h00, CW'(21), 1'b0, 1'b0, "R7");
        dump("R7", N);

        // R8, R2, R4: out-of-range column and the no-register code
        run_op(3'd0, 2'd0, '1, '0, 8'h00, '0, 1'b0, 1'b0, "R2");
        run_op(3'd5, 2'd0, '0, '0, 8'h00, CW'(45), 1'b0, 1'b0, "R8");
        run_op(3'd5, 2'd0, '0, '0, 8'h00, CW'(63), 1'b0, 1'b0, "R8");
        run_op(3'd5, 2'd3, '0, '0, 8'h00, CW'(5), 1'b0, 1'b0, "R8");
        run_op(3'd0, 2'd3, '0, '0, 8'h00, '0, 1'b0, 1'b0, "R2");
        run_op(3'd1, 2'd3, '0, '0, 8'hFF, '0, 1'b0, 1'b0, "R4");
        run_op(3'd5, 2'd1, '0, '0, 8'h00, CW'(22), 1'b0, 1'b0, "R8");
        run_op(3'd5, 2'd2, '0, '0, 8'h00, CW'(23), 1'b0, 1'b0, "R8");
        dump("R8", N);

        // R12: reserved opcodes
        run_op(3'd0, 2'd0, '1, '0, 8'h00, '0, 1'b0, 1'b0, "R2");
        run_op(3'd6, 2'd0, '1, '0, 8'hFF, CW'(3), 1'b1, 1'b0, "R12");
        run_op(3'd7, 2'd1, '1, '1, 8'hFF, CW'(7), 1'b0, 1'b0, "R12");
        dump("R12", N);

        // R10: destructive request held high through a busy window
        run_op(3'd0, 2'd0, '1, '0, 8'h00, '0, 1'b0, 1'b1, "R10");
        run_op(3'd1, 2'd1, '0, '0, 8'hAA, '0, 1'b0, 1'b1, "R10");
        dump("R10", N);

        // R6: multi-word write touches only selected words
        run_op(3'd0, 2'd0, 42'(1) << 12, 42'(1) << 12, 8'h00, '0, 1'b0, 1'b0, "R3");
        run_op(3'd3, 2'd0, 42'h2AB_CDEF_0123, '0, 8'h00, '0, 1'b0, 1'b0, "R6");
        run_op(3'd2, 2'd0, '0, '0, 8'h00, '0, 1'b0, 1'b0, "R6");
        dump("R6", 12);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule